// File: doc/BRIEF.md
# One-time-writable byte store with mode decode

This block is a cycle-level model of an 8192-entry, 8-bit memory whose cells can only be cleared by programming and set again by a global erase. Three active-low strobes (chip enable, output enable, program strobe) and two level flags pick the operating mode. One flag stands for the high programming supply. The other stands for the raised level on address line 9. The output is split into a data bus and a separate drive-enable, so that several instances can share one bus the way tri-state parts would.

With the supply flag low, the block reads stored bytes. With the raised-level flag set, it returns one of two fixed identification bytes. With the supply flag high, it accepts program strobes and lets the written bytes be verified. Programming ANDs the applied data into the addressed byte at the clock edge. A single-cycle erase input returns every byte to all ones. Access delays and electrical levels are not modelled: they show up only as the drive-enable and the cycle in which a write lands.

Top module: `otp_core`

## Requirements
- R1: After reset, every address reads 0xFF with the output driven.
- R2: With chip enable low, output enable low, supply flag low and raised-level flag low, the block drives the byte stored at the address, in the same cycle.
- R3: While chip enable is high, the drive-enable is low and the data bus is 0x00, whatever the other strobes and flags are.
- R4: With chip enable low and output enable high, the output is not driven.
- R5: With the supply flag high, chip enable low, program strobe low and output enable high, the clock edge replaces the addressed byte with its old value AND the input data. The output is not driven during that cycle.
- R6: A program strobe held low for several cycles with unchanged data and address leaves the same result as a single cycle.
- R7: A program strobe while the supply flag is low writes nothing.
- R8: With the supply flag high and chip enable high, a low program strobe writes nothing and the output stays undriven.
- R9: With the supply flag high, chip enable low, output enable low and program strobe high, the block drives the stored byte. The raised-level flag has no effect in this mode.
- R10: With the supply flag low, the raised-level flag high and both enables low, the block drives 0x9B when address bit 0 is 0 and 0x08 when it is 1. This does not depend on the array contents or on any other address bit.
- R11: A one-cycle erase sets every byte to 0xFF at the clock edge. It overrides a program request in the same cycle.
- R12: With the supply flag high and chip enable, output enable and program strobe all low, nothing is written and the output is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads all ones into the array |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| pgm_ni | input | 1 | Program strobe, active low |
| vpp_hi_i | input | 1 | Programming supply present |
| id_hv_i | input | 1 | Raised level on address line 9 |
| erase_i | input | 1 | One-cycle global erase |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | DATA_W | Data applied for programming |
| dout_o | output | DATA_W | Output data, 0 when not driven |
| dout_oe_o | output | 1 | Output drive enable |

## Verification
The two functions that can meet in one cycle are the global erase and a program strobe. The bench raises erase in the same cycle as a valid program request that carries all-zero data. It then reads back the whole address space and expects 0xFF at every address, including the address that was being programmed. A second overlap is output enable low during a program strobe under the supply flag. The bench judges this case by expecting an undriven bus and unchanged contents at that address on the following read.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_OUT_OFF,
    MODE_READ,
    MODE_IDENT,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_CLASH
  } otp_mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      ce_ni,
  input  logic      oe_ni,
  input  logic      pgm_ni,
  input  logic      vpp_hi_i,
  input  logic      id_hv_i,
  output otp_mode_e mode_o
);
  always_comb begin
    if (ce_ni) begin
      mode_o = vpp_hi_i ? MODE_INHIBIT : MODE_STANDBY;
    end else if (vpp_hi_i) begin
      unique case ({oe_ni, pgm_ni})
        2'b10:   mode_o = MODE_PROGRAM;
        2'b01:   mode_o = MODE_VERIFY;
        2'b00:   mode_o = MODE_CLASH;   // both strobes low: neither write nor drive
        default: mode_o = MODE_OUT_OFF;
      endcase
    end else if (oe_ni) begin
      mode_o = MODE_OUT_OFF;
    end else if (id_hv_i) begin
      mode_o = MODE_IDENT;
    end else begin
      mode_o = MODE_READ;
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int BANKS = 1 << BANK_W;
  localparam int ROW_W = ADDR_W - BANK_W;
  localparam int ROWS  = 1 << ROW_W;

  logic [BANK_W-1:0] bank_idx;
  logic [ROW_W-1:0]  row_idx;
  logic [DATA_W-1:0] bank_rd [BANKS];

  assign bank_idx = addr_i[BANK_W-1:0];
  assign row_idx  = addr_i[ADDR_W-1:BANK_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [ROWS];
    logic              sel;

    assign sel = wr_en_i && (bank_idx == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < ROWS; r++) mem_q[r] <= '1;
      end else if (erase_i) begin
        for (int r = 0; r < ROWS; r++) mem_q[r] <= '1;
      end else if (sel) begin
        // cells only move 1 -> 0
        mem_q[row_idx] <= mem_q[row_idx] & wdata_i;
      end
    end

    assign bank_rd[b] = mem_q[row_idx];
  end

  assign rdata_o = bank_rd[bank_idx];
endmodule

// File: rtl/otp_out_sel.sv
module otp_out_sel
  import otp_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter logic [DATA_W-1:0] ID_LO = 8'h9B,
  parameter logic [DATA_W-1:0] ID_HI = 8'h08
) (
  input  otp_mode_e         mode_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              id_sel_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  always_comb begin
    dout_o    = '0;
    dout_oe_o = 1'b0;
    unique case (mode_i)
      MODE_READ, MODE_VERIFY: begin
        dout_o    = rdata_i;
        dout_oe_o = 1'b1;
      end
      MODE_IDENT: begin
        dout_o    = id_sel_i ? ID_HI : ID_LO;
        dout_oe_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/otp_core.sv
module otp_core
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 3,
  parameter int ID_SEL_BIT = 0,
  parameter logic [DATA_W-1:0] ID_LO = 8'h9B,
  parameter logic [DATA_W-1:0] ID_HI = 8'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  otp_mode_e         mode;
  logic [DATA_W-1:0] rdata;
  logic              wr_en;

  otp_mode_dec u_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .pgm_ni   (pgm_ni),
    .vpp_hi_i (vpp_hi_i),
    .id_hv_i  (id_hv_i),
    .mode_o   (mode)
  );

  assign wr_en = (mode == MODE_PROGRAM);

  otp_cell_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W)
  ) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (erase_i),
    .wr_en_i (wr_en),
    .addr_i  (addr_i),
    .wdata_i (din_i),
    .rdata_o (rdata)
  );

  otp_out_sel #(
    .DATA_W (DATA_W),
    .ID_LO  (ID_LO),
    .ID_HI  (ID_HI)
  ) u_out (
    .mode_i    (mode),
    .rdata_i   (rdata),
    .id_sel_i  (addr_i[ID_SEL_BIT]),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o)
  );
endmodule

// File: rtl/otp_core_chk.sv
module otp_core_chk #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int ID_SEL_BIT = 0,
  parameter logic [DATA_W-1:0] ID_LO = 8'h9B,
  parameter logic [DATA_W-1:0] ID_HI = 8'h08
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              pgm_ni,
  input logic              vpp_hi_i,
  input logic              id_hv_i,
  input logic              erase_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_oe_o
);
  logic prog_req, verify_now, read_now, ident_now, clash_now;

  assign prog_req   = vpp_hi_i && !ce_ni && !pgm_ni && oe_ni;
  assign verify_now = vpp_hi_i && !ce_ni && !oe_ni && pgm_ni;
  assign read_now   = !vpp_hi_i && !ce_ni && !oe_ni && !id_hv_i;
  assign ident_now  = !vpp_hi_i && !ce_ni && !oe_ni && id_hv_i;
  assign clash_now  = vpp_hi_i && !ce_ni && !oe_ni && !pgm_ni;

  a_r3_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !dout_oe_o);

  // R2 / R4: drive only with both enables low
  a_r4_drive_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> (!ce_ni && !oe_ni));

  a_r5_program_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(prog_req && !erase_i) && verify_now && (addr_i == $past(addr_i)))
      |-> ((dout_o & ~$past(din_i)) == '0));

  a_r10_ident_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ident_now |-> (dout_oe_o && dout_o == (addr_i[ID_SEL_BIT] ? ID_HI : ID_LO)));

  a_r11_erase_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(erase_i) && read_now) |-> (dout_oe_o && dout_o == '1));

  a_r12_clash_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_now |-> !dout_oe_o);
endmodule

bind otp_core otp_core_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .ID_SEL_BIT (ID_SEL_BIT),
  .ID_LO      (ID_LO),
  .ID_HI      (ID_HI)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .pgm_ni    (pgm_ni),
  .vpp_hi_i  (vpp_hi_i),
  .id_hv_i   (id_hv_i),
  .erase_i   (erase_i),
  .addr_i    (addr_i),
  .din_i     (din_i),
  .dout_o    (dout_o),
  .dout_oe_o (dout_oe_o)
);

// File: tb/otp_core_tb_top.sv
module otp_core_tb_top;
  localparam int AW    = 13;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic          vpp = 1'b0, hv = 1'b0, er = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  otp_core dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ce_ni     (ce_n),
    .oe_ni     (oe_n),
    .pgm_ni    (pgm_n),
    .vpp_hi_i  (vpp),
    .id_hv_i   (hv),
    .erase_i   (er),
    .addr_i    (addr),
    .din_i     (din),
    .dout_o    (dout),
    .dout_oe_o (dout_oe)
  );

  function automatic logic [7:0] pat1(int a); return 8'(a * 37 + 11); endfunction
  function automatic logic [7:0] pat2(int a); return 8'(a ^ (a >> 5)) ^ 8'h5A; endfunction
  function automatic logic [7:0] pat3(int a); return 8'hF0 ^ 8'(a); endfunction
  function automatic logic [7:0] expd(int a);
    return pat1(a) & pat2(a) & ((a < 16) ? pat3(a) : 8'hFF);
  endfunction

  task automatic drive(input logic c, input logic o, input logic p, input logic v,
                       input logic h, input logic e, input int a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp = v; hv = h; er = e;
    addr = AW'(a); din = d;
    #2;
  endtask

  task automatic rd(input int a);           drive(0, 0, 1, 0, 0, 0, a, 8'h00); endtask
  task automatic vf(input int a);           drive(0, 0, 1, 1, 0, 0, a, 8'h00); endtask
  task automatic pg(input int a, input logic [7:0] d); drive(0, 1, 0, 1, 0, 0, a, d); endtask
  task automatic idle();                    drive(1, 1, 1, 0, 0, 0, 0, 8'h00); endtask

  task automatic chk(input string req, input int a, input logic [8:0] exp);
    n_cmp++;
    if ({dout_oe, dout} !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual={oe=%b,%h} expected={oe=%b,%h}",
               req, a, dout_oe, dout, exp[8], exp[7:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset content
    for (int a = 0; a < DEPTH; a++) begin rd(a); chk("R1", a, {1'b1, 8'hFF}); end

    // R3: chip enable high silences the bus
    for (int k = 0; k < 16; k++) begin
      drive(1, k[0], k[1], k[2], k[3], 0, 77, 8'h00);
      chk("R3", 77, 9'h000);
    end
    // R4: output enable high
    for (int k = 0; k < 4; k++) begin
      drive(0, 1, 1, k[0], k[1], 0, 78, 8'h00);
      chk("R4", 78, 9'h000);
    end
    rd(77); chk("R3", 77, {1'b1, 8'hFF});

    // R5: first program pass, bus undriven during strobe
    for (int a = 0; a < DEPTH; a++) begin pg(a, pat1(a)); chk("R5", a, 9'h000); end
    // R9: verify, raised-level flag ignored under supply
    for (int a = 0; a < DEPTH; a++) begin
      drive(0, 0, 1, 1, (a % 64) == 0, 0, a, 8'h00);
      chk("R9", a, {1'b1, pat1(a)});
    end

    // second pass and held strobes
    for (int a = 0; a < DEPTH; a++) pg(a, pat2(a));
    for (int a = 0; a < 16; a++) repeat (3) pg(a, pat3(a));

    for (int a = 0; a < DEPTH; a += 4) begin vf(a); chk("R5", a, {1'b1, expd(a)}); end
    for (int a = 0; a < DEPTH; a++) begin
      rd(a);
      chk((a < 16) ? "R6" : "R2", a, {1'b1, expd(a)});
    end

    // R7: strobe without supply
    for (int a = 100; a < 104; a++) begin
      drive(0, 1, 0, 0, 0, 0, a, 8'h00); chk("R7", a, 9'h000);
      rd(a); chk("R7", a, {1'b1, expd(a)});
    end
    // R8: inhibit by chip enable high
    for (int a = 200; a < 204; a++) begin
      drive(1, 0, 0, 1, 0, 0, a, 8'h00); chk("R8", a, 9'h000);
      rd(a); chk("R8", a, {1'b1, expd(a)});
    end
    // R12: both strobes low under supply
    for (int a = 300; a < 304; a++) begin
      drive(0, 0, 0, 1, 0, 0, a, 8'h00); chk("R12", a, 9'h000);
      rd(a); chk("R12", a, {1'b1, expd(a)});
    end

    // R10: identification bytes
    for (int a = 0; a < DEPTH; a += 13) begin
      drive(0, 0, 1, 0, 1, 0, a, 8'h00);
      chk("R10", a, {1'b1, (a % 2 == 1) ? 8'h08 : 8'h9B});
    end

    // R11: erase in the same cycle as a program request
    drive(0, 1, 0, 1, 0, 1, 5, 8'h00);
    idle();
    for (int a = 0; a < DEPTH; a++) begin rd(a); chk("R11", a, {1'b1, 8'hFF}); end

    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule